// File: doc/BRIEF.md
# Segment Address Translator

This block turns a two-part logical address (a segment number plus an offset inside that segment) into a physical address. Per-segment descriptors live in a table in memory. Two configuration inputs give the table's start address and the number of segments it holds. For each accepted request, the block first checks the segment number against the table size. If the number is in range, it fetches exactly one descriptor over a ready/valid memory port. It then checks the descriptor's valid flag, its length and its access rights. On success it returns the descriptor base plus the offset.

A requester presents a request with a valid/ready handshake and waits for one response. The response carries either a physical address or a 3-bit fault code. Only one request is in flight at a time. Checks run in a fixed order, and only the first one that fails is reported.

Top module: `seg_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_req_valid are both 0.
- R2: A request whose segment number is not below tbl_len gets fault code 1, and no descriptor read is issued for it.
- R3: For an in-range segment, exactly one descriptor read is issued, at address (tbl_base + segment) modulo 2^MA_W. While mem_req_ready is low, mem_req_valid and mem_req_addr stay unchanged.
- R4: A descriptor whose valid flag (entry bit 3) is 0 gives fault code 2.
- R5: An offset greater than or equal to the descriptor limit (entry bits 12:4, a 9-bit length) gives fault code 3.
- R6: Access types are encoded as 0 = read, 1 = write and 2 = execute. These are permitted by entry bits 0, 1 and 2 respectively. An access whose bit is clear, or the access type 3, gives fault code 4.
- R7: When all checks pass, the fault code is 0 and rsp_paddr is (base + offset) modulo 2^PA_W, where base is entry bits 24:13.
- R8: Checks apply in the order segment range, valid flag, limit, rights. Only the first failure is reported. The fault code never exceeds 4, and rsp_paddr is 0 whenever the fault code is nonzero.
- R9: req_ready stays low from acceptance until the response is taken. While rsp_ready is low, rsp_valid, rsp_paddr and rsp_fault are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute) |
| tbl_base | input | MA_W | Memory address of descriptor 0 |
| tbl_len | input | SEG_W+1 | Number of descriptors in the table |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | MA_W | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | ENTRY_W | Descriptor word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 ok, 1 range, 2 invalid, 3 limit, 4 rights |

## Verification
The assertions watch the following on every cycle:
- the holding of the response and of the descriptor read under backpressure;
- the rule of one request in flight;
- the legal range of fault codes;
- the zero address on a fault.

Only the bench's sweeps can show the behaviours that depend on data:
- the arithmetic result for each segment and offset;
- the correct first-failure ordering across descriptor contents;
- the exact descriptor address;
- the absence of any read for out-of-range segments.

The sweeps cover offsets on both sides of each limit, every access type, table sizes of zero, part and full, and a table base that wraps.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the segment translator: fault codes, access types, FSM states.
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_RIGHTS  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

endpackage

// File: rtl/seg_xlate_ctrl.sv
// Sequencer for the translator. Accepts one request, does the range check at
// acceptance, fetches one descriptor when in range, and holds the response
// until taken. Assumes tbl_base and tbl_len are stable while a request is accepted.
module seg_xlate_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int OFF_W   = 8,
    parameter int MA_W    = 16,
    parameter int ENTRY_W = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_acc,
    input  logic [MA_W-1:0]    tbl_base,
    input  logic [SEG_W:0]     tbl_len,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               range_bad_q,
    output logic [OFF_W-1:0]   off_q,
    output logic [1:0]         acc_q,
    output logic [ENTRY_W-1:0] entry_q
);

    state_e          state_q;
    logic [MA_W-1:0] addr_q;
    logic            seg_out;

    // Purpose: segment number outside the table at acceptance time.
    assign seg_out = ({1'b0, req_seg} >= tbl_len);

    // Purpose: state sequencing and capture of request and descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            range_bad_q <= 1'b0;
            off_q       <= '0;
            acc_q       <= '0;
            entry_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    range_bad_q <= seg_out;
                    off_q       <= req_off;
                    acc_q       <= req_acc;
                    addr_q      <= tbl_base + MA_W'(req_seg);
                    state_q     <= seg_out ? ST_RESP : ST_FETCH;
                end
                ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    entry_q <= mem_rsp_data;
                    state_q <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: handshake outputs decoded from state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_FETCH);
        rsp_valid     = (state_q == ST_RESP);
        mem_req_addr  = addr_q;
    end

endmodule

// File: rtl/seg_xlate_check.sv
// Descriptor decode and ordered checking. Purely combinational over the
// captured request and descriptor. Reports the first failing check and
// forms base + offset when all checks pass.
module seg_xlate_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W   = 8,
    parameter int PA_W    = 12,
    parameter int LIM_W   = 9,
    parameter int ENTRY_W = 25
) (
    input  logic               range_bad,
    input  logic [OFF_W-1:0]   off,
    input  logic [1:0]         acc,
    input  logic [ENTRY_W-1:0] entry,
    output logic [PA_W-1:0]    paddr,
    output logic [2:0]         fault
);

    localparam int LIM_LSB  = 4;
    localparam int BASE_LSB = LIM_LSB + LIM_W;

    logic [2:0]       rights;
    logic             present;
    logic [LIM_W-1:0] limit;
    logic [PA_W-1:0]  base;
    logic             allowed;
    fault_e           code;

    // Purpose: split the descriptor into its fields.
    always_comb begin
        rights  = entry[2:0];
        present = entry[3];
        limit   = entry[LIM_LSB +: LIM_W];
        base    = entry[BASE_LSB +: PA_W];
    end

    // Purpose: look up the rights bit for the requested access type.
    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allowed = rights[0];
            ACC_WRITE: allowed = rights[1];
            ACC_EXEC:  allowed = rights[2];
            default:   allowed = 1'b0;
        endcase
    end

    // Purpose: ordered checks; first failure wins.
    always_comb begin
        if (range_bad)                             code = FLT_RANGE;
        else if (!present)                         code = FLT_INVALID;
        else if (LIM_W'({1'b0, off}) >= limit)     code = FLT_LIMIT;
        else if (!allowed)                         code = FLT_RIGHTS;
        else                                       code = FLT_NONE;
    end

    // Purpose: result address, forced to zero on any fault.
    always_comb begin
        fault = code;
        paddr = (code == FLT_NONE) ? base + PA_W'(off) : '0;
    end

endmodule

// File: rtl/seg_xlate.sv
// Top of the segment translator: sequencer plus checker datapath.
// Descriptor word: [2:0] rights, [3] valid, [LIM_W+3:4] limit, above that base.
module seg_xlate #(
    parameter int SEG_W = 4,
    parameter int OFF_W = 8,
    parameter int PA_W  = 12,
    parameter int MA_W  = 16,
    parameter int LIM_W = OFF_W + 1,
    parameter int ENTRY_W = 4 + LIM_W + PA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_acc,
    input  logic [MA_W-1:0]    tbl_base,
    input  logic [SEG_W:0]     tbl_len,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [2:0]         rsp_fault
);

    logic               range_bad_q;
    logic [OFF_W-1:0]   off_q;
    logic [1:0]         acc_q;
    logic [ENTRY_W-1:0] entry_q;

    seg_xlate_ctrl #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .MA_W(MA_W), .ENTRY_W(ENTRY_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .tbl_base(tbl_base), .tbl_len(tbl_len),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .range_bad_q(range_bad_q), .off_q(off_q), .acc_q(acc_q),
        .entry_q(entry_q)
    );

    seg_xlate_check #(
        .OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W), .ENTRY_W(ENTRY_W)
    ) check_i (
        .range_bad(range_bad_q), .off(off_q), .acc(acc_q), .entry(entry_q),
        .paddr(rsp_paddr), .fault(rsp_fault)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
// Protocol checker for the segment translator, bound to every instance.
module seg_xlate_chk #(
    parameter int PA_W = 12,
    parameter int MA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [MA_W-1:0] mem_req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [2:0]      rsp_fault
);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    // R3
    memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid && !mem_req_valid);

    // R8
    fault_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd4);

    // R8
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 3'd0 |-> rsp_paddr == '0);

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W), .MA_W(MA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/seg_xlate_tb_top.sv
// Sweep bench: every segment, boundary offsets and every access type over
// three table configurations; expected results computed arithmetically.
module seg_xlate_tb_top;

    localparam int SEG_W = 4;
    localparam int OFF_W = 8;
    localparam int PA_W  = 12;
    localparam int MA_W  = 16;
    localparam int LIM_W = 9;
    localparam int ENTRY_W = 25;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [SEG_W-1:0]   req_seg = '0;
    logic [OFF_W-1:0]   req_off = '0;
    logic [1:0]         req_acc = '0;
    logic [MA_W-1:0]    tbl_base = '0;
    logic [SEG_W:0]     tbl_len = '0;
    logic               mem_req_valid;
    logic               mem_req_ready = 1'b1;
    logic [MA_W-1:0]    mem_req_addr;
    logic               mem_rsp_valid = 1'b0;
    logic [ENTRY_W-1:0] mem_rsp_data = '0;
    logic               rsp_valid;
    logic               rsp_ready = 1'b1;
    logic [PA_W-1:0]    rsp_paddr;
    logic [2:0]         rsp_fault;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    int tick = 0;
    int lat = 0;
    int pend = 0;
    int reads = 0;
    logic [MA_W-1:0] last_addr = '0;

    always #10 clk = ~clk;

    seg_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .tbl_base(tbl_base), .tbl_len(tbl_len),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic int e_base(int i); return (i * 613 + 37) % 4096; endfunction
    function automatic int e_lim(int i);  return (i * 37) % 300;        endfunction
    function automatic int e_vld(int i);  return (i % 5 != 3) ? 1 : 0;  endfunction
    function automatic int e_perm(int i); return i % 8;                 endfunction

    function automatic logic [ENTRY_W-1:0] entry_word(int i);
        return {12'(e_base(i)), 9'(e_lim(i)), 1'(e_vld(i)), 3'(e_perm(i))};
    endfunction

    // Memory model: ready pattern, variable latency, one word per handshake.
    always @(negedge clk) begin
        tick = tick + 1;
        mem_rsp_valid = 1'b0;
        if (pend == 1) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = entry_word(int'(16'(last_addr - tbl_base)));
        end
        if (pend > 0) pend = pend - 1;
        mem_req_ready = (tick % 3 != 0);
        if (mem_req_valid && mem_req_ready) begin
            last_addr = mem_req_addr;
            reads = reads + 1;
            pend = lat + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors = vectors + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL R9 watchdog actual=hang expected=response");
            finish_run();
        end
    end

    task automatic run_one(input int seg, input int off, input int acc,
                           input int len, input logic [MA_W-1:0] tb, input bit hold);
        int ef, ep, r0, waitc;
        int lim;
        logic [PA_W-1:0] p0;
        logic [2:0] f0;
        lim = e_lim(seg);
        if (seg >= len) ef = 1;
        else if (e_vld(seg) == 0) ef = 2;
        else if (off >= lim) ef = 3;
        else if (acc == 3 || ((e_perm(seg) >> acc) & 1) == 0) ef = 4;
        else ef = 0;
        ep = (ef == 0) ? (e_base(seg) + off) % 4096 : 0;

        r0 = reads;
        check("R9 idle ready", int'(req_ready), 1);
        req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waitc = 0;
        while (!rsp_valid && waitc < 50) begin
            if (req_ready) check("R9 ready low in flight", 1, 0);
            @(negedge clk);
            waitc = waitc + 1;
        end
        if (hold) begin
            rsp_ready = 1'b0;
            p0 = rsp_paddr; f0 = rsp_fault;
            @(negedge clk);
            @(negedge clk);
            check("R9 held valid", int'(rsp_valid), 1);
            check("R9 held fault", int'(rsp_fault), int'(f0));
            check("R9 held paddr", int'(rsp_paddr), int'(p0));
            rsp_ready = 1'b1;
        end
        if (ef == 0) check("R7 paddr", int'(rsp_paddr), ep);
        else check("R8 paddr zero on fault", int'(rsp_paddr), 0);
        case (ef)
            1: check("R2 range fault", int'(rsp_fault), ef);
            2: check("R4 invalid fault", int'(rsp_fault), ef);
            3: check("R5 limit fault", int'(rsp_fault), ef);
            4: check("R6 rights fault", int'(rsp_fault), ef);
            default: check("R7 no fault", int'(rsp_fault), ef);
        endcase
        if (seg >= len) check("R2 no descriptor read", reads - r0, 0);
        else begin
            check("R3 one descriptor read", reads - r0, 1);
            check("R3 descriptor address", int'(last_addr), int'(16'(tb + 16'(seg))));
        end
        @(negedge clk);
        check("R9 ready after response", int'(req_ready), 1);
    endtask

    initial begin
        int n;
        int offs [5];
        int lens [3];
        logic [MA_W-1:0] bases [3];
        lens[0] = 12; lens[1] = 16; lens[2] = 0;
        bases[0] = 16'h0100; bases[1] = 16'hFFF8; bases[2] = 16'h0000;
        repeat (3) @(negedge clk);
        check("R1 req_ready", int'(req_ready), 1);
        check("R1 rsp_valid", int'(rsp_valid), 0);
        check("R1 mem_req_valid", int'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        n = 0;
        for (int c = 0; c < 3; c++) begin
            tbl_len = 5'(lens[c]);
            tbl_base = bases[c];
            for (int s = 0; s < 16; s++) begin
                offs[0] = 0;
                offs[1] = (e_lim(s) - 1 < 0) ? 0 : ((e_lim(s) - 1 > 255) ? 255 : e_lim(s) - 1);
                offs[2] = (e_lim(s) > 255) ? 255 : e_lim(s);
                offs[3] = 255;
                offs[4] = 128;
                for (int o = 0; o < 5; o++) begin
                    for (int a = 0; a < 4; a++) begin
                        lat = n % 3;
                        run_one(s, offs[o], a, lens[c], bases[c], (n % 7) == 0);
                        n = n + 1;
                    end
                end
            end
        end
        finish_run();
    end

endmodule